// File: doc/BRIEF.md
# Limited-Pointer Sharer Tracker

This block holds the sharer record of one coherence directory entry. It does not keep a presence bit per node. It keeps a few encoded node pointers, each `$clog2(NODES)` bits wide, so 10 bits for 1024 nodes. Commands arrive on a valid/ready stream: add a sharer, remove a sharer, or a write by a node. A write turns the current record into a stream of invalidation targets, and then the writer is left as the only sharer.

While sharers fit in the pointer slots, no extra mechanism is used. When one sharer too many arrives, the `policy` input picks the overflow behaviour:
- **Broadcast fallback:** mark the entry as overflowed. The next write invalidates every node.
- **Evict:** displace an existing pointer in round-robin order and report the displaced node.
- **Coarse vector:** convert the entry to a vector with one bit per group of `GROUP` nodes.

When every sharer has been removed again, an overflowed entry falls back to plain pointer form.

Back-pressure rules on the two streams:
- A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is low while any invalidation beat is still waiting.
- An invalidation beat is held, with `inv_kind` and `inv_id` unchanged, until `inv_ready` is seen high.
- A beat leaves on each cycle where `inv_valid` and `inv_ready` are both high.

`victim_valid` is a plain pulse with no handshake.

Top module: `dir_lp_entry`

## Requirements
- R1: After reset, `cmd_ready` is 1, `inv_valid` is 0 and `victim_valid` is 0, and the entry records no sharer.
- R2: Add, remove and unused commands (`cmd_op` 0 add, 1 remove, 2 write, 3 ignored) never create an invalidation beat. An added node that is not already recorded takes the lowest free pointer slot.
- R3: Adding a node that is already recorded changes nothing and uses no slot.
- R4: A write by node W on an entry that is not overflowed emits one beat of kind 0 (node) for each recorded sharer other than W, in ascending slot order. The beats begin the cycle after the write is accepted. Afterwards the entry holds only W, in slot 0.
- R5: With `policy` 0 (or 3), an add that finds all slots full puts the entry in broadcast overflow. The next write then emits exactly one beat of kind 2 (all nodes) with `inv_id` 0.
- R6: With `policy` 1, an add that finds all slots full replaces the slot chosen round-robin. The pointer starts at slot 0 after reset and advances one slot per eviction. In the next cycle `victim_valid` is high for one cycle and `victim_id` carries the displaced node.
- R7: With `policy` 2, an add that finds all slots full converts the entry to a coarse vector. The vector covers the groups of all recorded sharers and of every later added node, where group = node / `GROUP`. A write emits one beat of kind 1 (group) per set bit, in ascending group order, with `inv_id` set to the group index.
- R8: Removing a recorded node frees its slot. Removing a node that is not recorded, while the entry is not overflowed, changes nothing.
- R9: Once every pointer is cleared and every sharer added beyond capacity has been removed, an overflowed entry returns to empty pointer form. After that, writes emit node beats only.
- R10: While `inv_valid` is high and `inv_ready` is low, the beat stays unchanged. `cmd_ready` is low while any beat is pending.
- R11: A write by the only recorded sharer, or to an empty entry, emits no beat, and `cmd_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| policy | input | 2 | Overflow policy: 0 broadcast, 1 evict, 2 coarse vector, 3 broadcast |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_op | input | 2 | 0 add, 1 remove, 2 write, 3 ignored |
| cmd_node | input | IDW | Node ID of the command |
| inv_valid | output | 1 | Invalidation beat valid |
| inv_ready | input | 1 | Sink takes beat when high with valid |
| inv_kind | output | 2 | 0 node, 1 group, 2 all nodes |
| inv_id | output | IDW | Node ID or group index (0 for all) |
| victim_valid | output | 1 | One-cycle pulse: a pointer was displaced |
| victim_id | output | IDW | Displaced node ID |

## Verification
The bench targets duplicate adds (a design that spent a slot on them would overflow too early and send a broadcast instead of node beats), round-robin victim order (a fixed victim slot would report the wrong displaced node on the second eviction), and coarse conversion (a design that dropped the groups of the pointers held at conversion would miss groups in the write). It also covers recovery from overflow after every sharer is removed, where a stuck overflow flag would keep sending broadcast or group beats. Finally, it holds `inv_ready` low in the middle of a write, so a design that dropped or changed a stalled beat, or accepted a command too early, would be caught.

// File: rtl/dir_lp_pkg.sv
package dir_lp_pkg;
  typedef enum logic [1:0] {
    OP_ADD    = 2'd0,
    OP_REMOVE = 2'd1,
    OP_WRITE  = 2'd2,
    OP_IDLE   = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    KIND_NODE  = 2'd0,
    KIND_GROUP = 2'd1,
    KIND_ALL   = 2'd2
  } inv_kind_e;

  typedef enum logic [1:0] {
    MODE_PTR    = 2'd0,
    MODE_BCAST  = 2'd1,
    MODE_COARSE = 2'd2
  } ovf_mode_e;

  localparam logic [1:0] POL_EVICT  = 2'd1;
  localparam logic [1:0] POL_COARSE = 2'd2;
endpackage

// File: rtl/dir_first_set.sv
module dir_first_set #(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/dir_ptr_match.sv
module dir_ptr_match #(
  parameter int NPTR = 4,
  parameter int IDW  = 10,
  parameter int PW   = 2
) (
  input  logic [NPTR-1:0]          vld,
  input  logic [NPTR-1:0][IDW-1:0] ids,
  input  logic [IDW-1:0]           key,
  output logic [NPTR-1:0]          eq,
  output logic                     hit,
  output logic [PW-1:0]            hit_idx,
  output logic                     has_free,
  output logic [PW-1:0]            free_idx
);
  for (genvar i = 0; i < NPTR; i++) begin : g_cmp
    assign eq[i] = vld[i] && (ids[i] == key);
  end

  dir_first_set #(.W(NPTR), .IW(PW)) u_hit (
    .vec(eq), .found(hit), .idx(hit_idx)
  );

  dir_first_set #(.W(NPTR), .IW(PW)) u_free (
    .vec(~vld), .found(has_free), .idx(free_idx)
  );
endmodule

// File: rtl/dir_group_map.sv
module dir_group_map #(
  parameter int NPTR = 4,
  parameter int NGRP = 16,
  parameter int GW   = 4
) (
  input  logic [NPTR-1:0]         vld,
  input  logic [NPTR-1:0][GW-1:0] grp_ix,
  input  logic [GW-1:0]           key_ix,
  output logic [NGRP-1:0]         ptr_mask,
  output logic [NGRP-1:0]         key_mask
);
  always_comb begin
    ptr_mask = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (vld[i]) ptr_mask[grp_ix[i]] = 1'b1;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_key
    assign key_mask[g] = (key_ix == GW'(g));
  end
endmodule

// File: rtl/dir_lp_entry.sv
module dir_lp_entry
  import dir_lp_pkg::*;
#(
  parameter int NODES = 1024,
  parameter int NPTR  = 4,
  parameter int GROUP = 64,
  localparam int IDW  = $clog2(NODES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     policy,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [IDW-1:0] cmd_node,
  output logic           inv_valid,
  input  logic           inv_ready,
  output logic [1:0]     inv_kind,
  output logic [IDW-1:0] inv_id,
  output logic           victim_valid,
  output logic [IDW-1:0] victim_id
);
  localparam int PW   = (NPTR > 1) ? $clog2(NPTR) : 1;
  localparam int GSH  = $clog2(GROUP);
  localparam int NGRP = NODES / GROUP;
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int CW   = IDW + 1;
  localparam logic [CW-1:0] CMAX = '1;

  // entry state
  logic [NPTR-1:0]          ptr_v,  ptr_v_n;
  logic [NPTR-1:0][IDW-1:0] ptr_id, ptr_id_n;
  ovf_mode_e                ovf,    ovf_n;
  logic [CW-1:0]            ocnt,   ocnt_n;
  logic [NGRP-1:0]          grp,    grp_n;
  logic [PW-1:0]            rr,     rr_n;
  // pending invalidation state
  logic [NPTR-1:0]          snap_v,  snap_v_n;
  logic [NPTR-1:0][IDW-1:0] snap_id, snap_id_n;
  logic [NGRP-1:0]          gpend,   gpend_n;
  logic                     apend,   apend_n;
  logic                     vic_v,   vic_v_n;
  logic [IDW-1:0]           vic_id,  vic_id_n;

  logic [NPTR-1:0]         eq;
  logic                    hit, has_free;
  logic [PW-1:0]           hit_idx, free_idx;
  logic [NPTR-1:0][GW-1:0] ptr_gix;
  logic [NGRP-1:0]         ptr_gmask, key_gmask;
  logic                    s_found, g_found;
  logic [PW-1:0]           s_idx;
  logic [GW-1:0]           g_idx;
  logic                    pending, accept, drain;

  dir_ptr_match #(.NPTR(NPTR), .IDW(IDW), .PW(PW)) u_match (
    .vld(ptr_v), .ids(ptr_id), .key(cmd_node), .eq(eq),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_gix
    assign ptr_gix[i] = ptr_id[i][IDW-1:GSH];
  end

  dir_group_map #(.NPTR(NPTR), .NGRP(NGRP), .GW(GW)) u_gmap (
    .vld(ptr_v), .grp_ix(ptr_gix), .key_ix(cmd_node[IDW-1:GSH]),
    .ptr_mask(ptr_gmask), .key_mask(key_gmask)
  );

  dir_first_set #(.W(NPTR), .IW(PW)) u_snap_pick (
    .vec(snap_v), .found(s_found), .idx(s_idx)
  );

  dir_first_set #(.W(NGRP), .IW(GW)) u_grp_pick (
    .vec(gpend), .found(g_found), .idx(g_idx)
  );

  assign pending      = apend || g_found || s_found;
  assign cmd_ready    = !pending;
  assign accept       = cmd_valid && cmd_ready;
  assign inv_valid    = pending;
  assign drain        = inv_valid && inv_ready;
  assign victim_valid = vic_v;
  assign victim_id    = vic_id;

  always_comb begin
    if (apend) begin
      inv_kind = KIND_ALL;
      inv_id   = '0;
    end else if (g_found) begin
      inv_kind = KIND_GROUP;
      inv_id   = IDW'(g_idx);
    end else begin
      inv_kind = KIND_NODE;
      inv_id   = snap_id[s_idx];
    end
  end

  always_comb begin
    ptr_v_n   = ptr_v;
    ptr_id_n  = ptr_id;
    ovf_n     = ovf;
    ocnt_n    = ocnt;
    grp_n     = grp;
    rr_n      = rr;
    snap_v_n  = snap_v;
    snap_id_n = snap_id;
    gpend_n   = gpend;
    apend_n   = apend;
    vic_v_n   = 1'b0;
    vic_id_n  = vic_id;

    if (drain) begin
      if (apend)        apend_n         = 1'b0;
      else if (g_found) gpend_n[g_idx]  = 1'b0;
      else              snap_v_n[s_idx] = 1'b0;
    end

    if (accept) begin
      case (cmd_op)
        OP_ADD: begin
          if (!hit) begin
            if (has_free) begin
              ptr_v_n[free_idx]  = 1'b1;
              ptr_id_n[free_idx] = cmd_node;
              if (ovf == MODE_COARSE) grp_n = grp | key_gmask;
            end else if (ovf == MODE_BCAST) begin
              if (ocnt != CMAX) ocnt_n = ocnt + 1'b1;
            end else if (ovf == MODE_COARSE) begin
              grp_n = grp | key_gmask;
              if (ocnt != CMAX) ocnt_n = ocnt + 1'b1;
            end else if (policy == POL_EVICT) begin
              vic_v_n      = 1'b1;
              vic_id_n     = ptr_id[rr];
              ptr_id_n[rr] = cmd_node;
              rr_n         = (rr == PW'(NPTR - 1)) ? '0 : rr + 1'b1;
            end else if (policy == POL_COARSE) begin
              ovf_n  = MODE_COARSE;
              grp_n  = ptr_gmask | key_gmask;
              ocnt_n = CW'(1);
            end else begin
              ovf_n  = MODE_BCAST;
              ocnt_n = CW'(1);
            end
          end
        end
        OP_REMOVE: begin
          if (hit) ptr_v_n[hit_idx] = 1'b0;
          else if (ovf != MODE_PTR && ocnt != '0) ocnt_n = ocnt - 1'b1;
          if (ovf != MODE_PTR && ptr_v_n == '0 && ocnt_n == '0) begin
            ovf_n = MODE_PTR;
            grp_n = '0;
          end
        end
        OP_WRITE: begin
          apend_n     = (ovf == MODE_BCAST);
          gpend_n     = (ovf == MODE_COARSE) ? grp : '0;
          snap_v_n    = (ovf == MODE_PTR) ? (ptr_v & ~eq) : '0;
          snap_id_n   = ptr_id;
          ptr_v_n     = '0;
          ptr_v_n[0]  = 1'b1;
          ptr_id_n[0] = cmd_node;
          ovf_n       = MODE_PTR;
          ocnt_n      = '0;
          grp_n       = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_v   <= '0;
      ptr_id  <= '0;
      ovf     <= MODE_PTR;
      ocnt    <= '0;
      grp     <= '0;
      rr      <= '0;
      snap_v  <= '0;
      snap_id <= '0;
      gpend   <= '0;
      apend   <= 1'b0;
      vic_v   <= 1'b0;
      vic_id  <= '0;
    end else begin
      ptr_v   <= ptr_v_n;
      ptr_id  <= ptr_id_n;
      ovf     <= ovf_n;
      ocnt    <= ocnt_n;
      grp     <= grp_n;
      rr      <= rr_n;
      snap_v  <= snap_v_n;
      snap_id <= snap_id_n;
      gpend   <= gpend_n;
      apend   <= apend_n;
      vic_v   <= vic_v_n;
      vic_id  <= vic_id_n;
    end
  end
endmodule

// File: rtl/dir_lp_entry_chk.sv
module dir_lp_entry_chk #(
  parameter int NODES = 1024,
  parameter int NPTR  = 4,
  parameter int GROUP = 64,
  localparam int IDW  = $clog2(NODES)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     policy,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [1:0]     cmd_op,
  input logic           inv_valid,
  input logic           inv_ready,
  input logic [1:0]     inv_kind,
  input logic [IDW-1:0] inv_id,
  input logic           victim_valid
);
  localparam int NGRP = NODES / GROUP;

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_id) && $stable(inv_kind));

  assert_busy_blocks_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !cmd_ready);

  assert_no_beat_from_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op != 2'd2 |=> !inv_valid);

  assert_victim_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd0 && policy == 2'd1));

  assert_single_all_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && inv_kind == 2'd2 |=> !inv_valid);

  assert_group_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_kind == 2'd1 |-> inv_id < IDW'(NGRP));
endmodule

bind dir_lp_entry dir_lp_entry_chk #(.NODES(NODES), .NPTR(NPTR), .GROUP(GROUP)) u_chk (.*);

// File: tb/dir_lp_entry_test.sv
module dir_lp_entry_test;
  localparam int NODES = 1024;
  localparam int NPTR  = 4;
  localparam int GROUP = 64;
  localparam int IDW   = 10;
  localparam int NGRP  = NODES / GROUP;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     policy;
  logic           cmd_valid;
  logic           cmd_ready;
  logic [1:0]     cmd_op;
  logic [IDW-1:0] cmd_node;
  logic           inv_valid;
  logic           inv_ready;
  logic [1:0]     inv_kind;
  logic [IDW-1:0] inv_id;
  logic           victim_valid;
  logic [IDW-1:0] victim_id;

  always #2.5 clk = ~clk;

  dir_lp_entry #(.NODES(NODES), .NPTR(NPTR), .GROUP(GROUP)) uut (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_node(cmd_node),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_kind(inv_kind), .inv_id(inv_id),
    .victim_valid(victim_valid), .victim_id(victim_id)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  // reference model
  bit m_v[NPTR];
  int m_id[NPTR];
  int m_mode = 0;      // 0 pointers, 1 broadcast overflow, 2 coarse
  int m_cnt  = 0;
  bit m_grp[NGRP];
  int m_rr   = 0;
  int q_kind[$];
  int q_id[$];
  bit m_vic  = 0;
  int m_vid  = 0;
  bit last_acc;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cmd_ready == (q_kind.size() == 0), "cmd_ready", int'(cmd_ready), int'(q_kind.size() == 0));
    chk(inv_valid == (q_kind.size() != 0), "inv_valid", int'(inv_valid), int'(q_kind.size() != 0));
    if (q_kind.size() != 0 && inv_valid) begin
      chk(int'(inv_kind) == q_kind[0], "inv_kind", int'(inv_kind), q_kind[0]);
      chk(int'(inv_id) == q_id[0], "inv_id", int'(inv_id), q_id[0]);
    end
    chk(victim_valid == m_vic, "victim_valid", int'(victim_valid), int'(m_vic));
    if (m_vic && victim_valid) chk(int'(victim_id) == m_vid, "victim_id", int'(victim_id), m_vid);
  endtask

  task automatic model_apply(input int op, input int n, input int pol);
    int hit = -1;
    int fr  = -1;
    bit any;
    for (int i = NPTR - 1; i >= 0; i--) begin
      if (m_v[i] && m_id[i] == n) hit = i;
      if (!m_v[i]) fr = i;
    end
    if (op == 0) begin
      if (hit < 0) begin
        if (fr >= 0) begin
          m_v[fr] = 1; m_id[fr] = n;
          if (m_mode == 2) m_grp[n / GROUP] = 1;
        end else if (m_mode == 1) m_cnt++;
        else if (m_mode == 2) begin m_grp[n / GROUP] = 1; m_cnt++; end
        else if (pol == 1) begin
          m_vic = 1; m_vid = m_id[m_rr]; m_id[m_rr] = n; m_rr = (m_rr + 1) % NPTR;
        end else if (pol == 2) begin
          m_mode = 2; m_cnt = 1;
          for (int i = 0; i < NPTR; i++) m_grp[m_id[i] / GROUP] = 1;
          m_grp[n / GROUP] = 1;
        end else begin
          m_mode = 1; m_cnt = 1;
        end
      end
    end else if (op == 1) begin
      if (hit >= 0) m_v[hit] = 0;
      else if (m_mode != 0 && m_cnt > 0) m_cnt--;
      any = 0;
      for (int i = 0; i < NPTR; i++) any |= m_v[i];
      if (m_mode != 0 && !any && m_cnt == 0) begin
        m_mode = 0;
        for (int g = 0; g < NGRP; g++) m_grp[g] = 0;
      end
    end else if (op == 2) begin
      if (m_mode == 1) begin q_kind.push_back(2); q_id.push_back(0); end
      else if (m_mode == 2) begin
        for (int g = 0; g < NGRP; g++) if (m_grp[g]) begin q_kind.push_back(1); q_id.push_back(g); end
      end else begin
        for (int i = 0; i < NPTR; i++) if (m_v[i] && m_id[i] != n) begin q_kind.push_back(0); q_id.push_back(m_id[i]); end
      end
      for (int i = 0; i < NPTR; i++) m_v[i] = 0;
      for (int g = 0; g < NGRP; g++) m_grp[g] = 0;
      m_v[0] = 1; m_id[0] = n; m_mode = 0; m_cnt = 0;
    end
  endtask

  task automatic step();
    bit acc;
    bit pop;
    @(posedge clk);
    acc = cmd_valid && (q_kind.size() == 0);
    pop = (q_kind.size() != 0) && inv_ready;
    m_vic = 0;
    if (pop) begin void'(q_kind.pop_front()); void'(q_id.pop_front()); end
    if (acc) model_apply(int'(cmd_op), int'(cmd_node), int'(policy));
    last_acc = acc;
    #1;
    compare();
  endtask

  task automatic cmd(input int op, input int n);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_node  = IDW'(n);
    do step(); while (!last_acc);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_kind.size() != 0) step();
    step();
  endtask

  task automatic wr(input int n);
    cmd(2, n);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPTR; i++) begin m_v[i] = 0; m_id[i] = 0; end
    for (int g = 0; g < NGRP; g++) m_grp[g] = 0;
    rst_n = 1'b0; policy = 2'd0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_node = '0; inv_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; compare(); step(); step();

    cur_req = "R11"; wr(3); wr(3);

    cur_req = "R2"; cmd(0, 10); cmd(0, 20); cmd(3, 44); step();
    cur_req = "R3"; cmd(0, 20); cmd(0, 30);
    cur_req = "R4"; wr(20);
    cur_req = "R3"; cmd(0, 20); cmd(0, 40); cmd(0, 50); cmd(0, 60); wr(99);

    cur_req = "R5"; policy = 2'd0;
    cmd(0, 1); cmd(0, 2); cmd(0, 3); cmd(0, 4); wr(7);
    policy = 2'd3; cmd(0, 1); cmd(0, 2); cmd(0, 3); cmd(0, 4); cmd(0, 5); wr(7);

    cur_req = "R6"; policy = 2'd1;
    cmd(0, 11); cmd(0, 12); cmd(0, 13); cmd(0, 14); cmd(0, 15); cmd(0, 16); step();
    wr(12);

    cur_req = "R7"; policy = 2'd2;
    cmd(0, 100); cmd(0, 200); cmd(0, 300); cmd(0, 900); cmd(0, 130); cmd(0, 1023); wr(5);

    cur_req = "R8"; policy = 2'd0;
    cmd(1, 77); cmd(0, 6); cmd(1, 5); cmd(1, 5); wr(8);

    cur_req = "R9";
    cmd(0, 1); cmd(0, 2); cmd(0, 3); cmd(0, 4); cmd(0, 9);
    cmd(1, 4); cmd(1, 9); cmd(1, 8); cmd(1, 1); cmd(1, 2); cmd(1, 3);
    cmd(0, 50); wr(51);
    policy = 2'd2;
    cmd(0, 52); cmd(0, 53); cmd(0, 54); cmd(0, 555);
    cmd(1, 51); cmd(1, 52); cmd(1, 53); cmd(1, 54); cmd(1, 555);
    cmd(0, 60); wr(61);

    cur_req = "R10"; policy = 2'd0;
    cmd(0, 1); cmd(0, 2); cmd(0, 3);
    inv_ready = 1'b0;
    cmd(2, 0);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_node = IDW'(77);
    repeat (3) step();
    cmd_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      inv_ready = k[0];
      step();
    end
    inv_ready = 1'b1;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule